// File: doc/BRIEF.md
# Legacy Status Port Ready Handshake

This block produces the ready flag and the returned data byte behind an 8-bit legacy status port that sits at offset 8 of a snooped I/O window. A 2-bit source-select input picks where the ready flag comes from: the flag can be held low, follow the DMA terminal-count indication, follow the terminal count ORed with the legacy DMA request, or come from a handshake register.

In handshake mode a status write strobe raises the flag and captures a return byte. The byte is mostly the supplied input byte, but two of its bit positions are replaced by the matching bits of a DMA request byte. Which two positions are replaced depends on whether DMA channel 0 is active. The flag drops again when a read of offset 8 is snooped on the bus. The decode of that read is limited to the three qualifiers the block receives. All other bus decode is done elsewhere.

Top module: `legacy_status_ready`

## Requirements
- R1: With source select 00, `status_rdy` is 0 whatever the other inputs are.
- R2: With source select 01, `status_rdy` equals `dma_tc_hit` in the same cycle.
- R3: With source select 10, `status_rdy` equals `dma_tc_hit | legacy_req` in the same cycle.
- R4: After reset the handshake flag is 0 and `ret_byte` is 00h, so `status_rdy` reads 0 under source select 11 until a strobe arrives.
- R5: Under source select 11, `stat_wr` high at a clock edge makes `status_rdy` 1 from that edge on.
- R6: A strobe taken with `dma_chan` equal to 0 loads `ret_byte` with bits 0 and 4 taken from `dma_req_byte` and bits 1, 2, 3, 5, 6 and 7 taken from `in_byte`.
- R7: A strobe taken with any nonzero `dma_chan` loads `ret_byte` with bits 1 and 5 taken from `dma_req_byte` and the other six bits taken from `in_byte`.
- R8: Under source select 11, a set flag clears at the edge where `snoop_cs_n` is 0, `snoop_addr` equals 08h and `data_rdy_n` is 0. If any one of these three conditions is missing, the flag stays set.
- R9: When a strobe and a qualifying snooped read happen at the same edge, the flag ends up set.
- R10: `ret_byte` changes only at an edge where a strobe is taken, so a snooped read or a change of `in_byte` or `dma_req_byte` has no effect on it.
- R11: Moving the source select away from 11 neither clears nor sets the handshake flag. Snooped reads during that time do not touch it, and returning to 11 shows the flag as it was left.
- R12: A strobe while the source select is not 11 is ignored: neither the flag nor `ret_byte` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Ready flag source select (00 off, 01 terminal count, 10 terminal count or request, 11 handshake) |
| dma_tc_hit | input | 1 | DMA terminal count reached |
| legacy_req | input | 1 | Legacy DMA request |
| stat_wr | input | 1 | Status write strobe |
| in_byte | input | 8 | Byte supplied for the return value |
| dma_req_byte | input | 8 | DMA request bits spliced into the return value |
| dma_chan | input | CHAN_W | Active DMA channel number |
| snoop_cs_n | input | 1 | Snoop chip select, active low |
| snoop_addr | input | ADDR_W | Low byte of the snooped address |
| data_rdy_n | input | 1 | Snooped data ready, active low |
| status_rdy | output | 1 | Ready flag |
| ret_byte | output | 8 | Return byte latched on the strobe |

## Verification
The bench builds the block with its defaults: a 2-bit channel field, an 8-bit snooped address and a status offset of 08h. A 2-bit channel field is small enough to sweep every channel code, so channel 0 and all three nonzero channels are each driven against a spread of input and request bytes. The same small configuration also allows a full sweep of every source select against both terminal-count and request levels. The bench drives every combination of the three snoop qualifiers, including addresses that differ from 08h only in a low bit or only in the top bit.

// File: rtl/lsr_pkg.sv
// Package lsr_pkg
// Shared types and constants of the legacy status ready block.
// Assumes a byte-wide return value; the splice masks are fixed by behaviour.
package lsr_pkg;

    typedef enum logic [1:0] {
        SRC_OFF       = 2'b00,
        SRC_TC        = 2'b01,
        SRC_TC_OR_REQ = 2'b10,
        SRC_HANDSHAKE = 2'b11
    } rdy_src_e;

    localparam int BYTE_W = 8;

    // Bit positions replaced by request bits: channel 0, then any other channel
    localparam logic [BYTE_W-1:0] SPLICE_CH0   = 8'h11;
    localparam logic [BYTE_W-1:0] SPLICE_OTHER = 8'h22;

endpackage

// File: rtl/lsr_splice.sv
// Module lsr_splice
// Builds the return byte by replacing selected bits of the input byte with
// the matching DMA request bits; the replaced positions depend on whether
// channel 0 is active. Purely combinational.
module lsr_splice
    import lsr_pkg::*;
#(
    parameter int CHAN_W = 2
) (
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [BYTE_W-1:0] dreq_byte,
    input  logic [CHAN_W-1:0] chan,
    output logic [BYTE_W-1:0] merged
);

    logic [BYTE_W-1:0] take_dreq;

    // Pick the position mask for the active channel
    always_comb begin
        take_dreq = (chan == '0) ? SPLICE_CH0 : SPLICE_OTHER;
    end

    // Per-bit choice between input byte and request byte
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign merged[b] = take_dreq[b] ? dreq_byte[b] : in_byte[b];
    end

endmodule

// File: rtl/lsr_snoop_match.sv
// Module lsr_snoop_match
// Flags a snooped read of the status offset from the three bus qualifiers.
// Assumes the qualifiers are already synchronous to clk.
module lsr_snoop_match #(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h08
) (
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rdy_n,
    output logic              hit
);

    // All three qualifiers must be active at once
    always_comb begin
        hit = !cs_n && (addr == STATUS_ADDR) && !rdy_n;
    end

endmodule

// File: rtl/lsr_hs_reg.sv
// Module lsr_hs_reg
// Handshake flag and return byte registers. Acts only while hs_en is high;
// otherwise both registers hold. A strobe wins over a clearing read.
module lsr_hs_reg
    import lsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_en,
    input  logic              set_stb,
    input  logic              snoop_hit,
    input  logic [BYTE_W-1:0] merged,
    output logic              flag_q,
    output logic [BYTE_W-1:0] ret_q
);

    // Handshake flag: set by strobe, cleared by snooped read, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hs_en) begin
            if (set_stb) begin
                flag_q <= 1'b1;
            end else if (snoop_hit && flag_q) begin
                flag_q <= 1'b0;
            end
        end
    end

    // Return byte: captured only on an accepted strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else if (hs_en && set_stb) begin
            ret_q <= merged;
        end
    end

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && set_stb) |=> flag_q);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && set_stb && snoop_hit) |=> flag_q);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !set_stb && snoop_hit && flag_q) |=> !flag_q);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && set_stb) |=> $stable(ret_q));

    p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_en |=> $stable(flag_q));

endmodule

// File: rtl/legacy_status_ready.sv
// Module legacy_status_ready
// Ready flag and return byte of the legacy status port. The source select
// chooses between off, terminal count, terminal count or request, and the
// handshake register. Assumes all inputs are synchronous to clk.
module legacy_status_ready
    import lsr_pkg::*;
#(
    parameter int                CHAN_W      = 2,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              dma_tc_hit,
    input  logic              legacy_req,
    input  logic              stat_wr,
    input  logic [7:0]        in_byte,
    input  logic [7:0]        dma_req_byte,
    input  logic [CHAN_W-1:0] dma_chan,
    input  logic              snoop_cs_n,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              data_rdy_n,
    output logic              status_rdy,
    output logic [7:0]        ret_byte
);

    rdy_src_e          src;
    logic              hs_en;
    logic              read_hit;
    logic              hs_flag;
    logic [BYTE_W-1:0] spliced;

    // Decode the source select
    always_comb begin
        src   = rdy_src_e'(mode_sel);
        hs_en = (src == SRC_HANDSHAKE);
    end

    lsr_splice #(.CHAN_W(CHAN_W)) u_splice (
        .in_byte  (in_byte),
        .dreq_byte(dma_req_byte),
        .chan     (dma_chan),
        .merged   (spliced)
    );

    lsr_snoop_match #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_match (
        .cs_n (snoop_cs_n),
        .addr (snoop_addr),
        .rdy_n(data_rdy_n),
        .hit  (read_hit)
    );

    lsr_hs_reg u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_en    (hs_en),
        .set_stb  (stat_wr),
        .snoop_hit(read_hit),
        .merged   (spliced),
        .flag_q   (hs_flag),
        .ret_q    (ret_byte)
    );

    // Select the ready flag source
    always_comb begin
        unique case (src)
            SRC_OFF:       status_rdy = 1'b0;
            SRC_TC:        status_rdy = dma_tc_hit;
            SRC_TC_OR_REQ: status_rdy = dma_tc_hit | legacy_req;
            default:       status_rdy = hs_flag;
        endcase
    end

    p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |-> !status_rdy);

    p_tc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |-> (status_rdy == dma_tc_hit));

    p_tc_or_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10) |-> (status_rdy == (dma_tc_hit | legacy_req)));

    p_splice_ch0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && stat_wr && dma_chan == '0) |=>
        (ret_byte[4] == $past(dma_req_byte[4]) && ret_byte[0] == $past(dma_req_byte[0])));

    p_splice_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && stat_wr && dma_chan != '0) |=>
        (ret_byte[5] == $past(dma_req_byte[5]) && ret_byte[1] == $past(dma_req_byte[1])));

    p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b11) |=> $stable(ret_byte));

endmodule

// File: tb/legacy_status_ready_bench.sv
`timescale 1ns/1ps
module legacy_status_ready_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b11;
    logic       dma_tc_hit = 1'b0;
    logic       legacy_req = 1'b0;
    logic       stat_wr = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] dma_req_byte = 8'h00;
    logic [1:0] dma_chan = 2'd0;
    logic       snoop_cs_n = 1'b1;
    logic [7:0] snoop_addr = 8'h00;
    logic       data_rdy_n = 1'b1;
    logic       status_rdy;
    logic [7:0] ret_byte;

    int tests = 0;
    int fails = 0;
    logic [7:0] held;

    always #4 clk = ~clk;

    legacy_status_ready u_legacy_status_ready (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .dma_tc_hit(dma_tc_hit), .legacy_req(legacy_req),
        .stat_wr(stat_wr), .in_byte(in_byte), .dma_req_byte(dma_req_byte),
        .dma_chan(dma_chan), .snoop_cs_n(snoop_cs_n), .snoop_addr(snoop_addr),
        .data_rdy_n(data_rdy_n), .status_rdy(status_rdy), .ret_byte(ret_byte)
    );

    function automatic logic [7:0] expect_byte(input logic [7:0] v, input logic [7:0] d,
                                               input logic [1:0] ch);
        if (ch == 2'd0) return {v[7:5], d[4], v[3:1], d[0]};
        return {v[7:6], d[5], v[4], v[3:2], d[1], v[0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic snoop_idle();
        snoop_cs_n = 1'b1; snoop_addr = 8'h00; data_rdy_n = 1'b1;
    endtask

    task automatic snoop_full();
        snoop_cs_n = 1'b0; snoop_addr = 8'h08; data_rdy_n = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] v, input logic [7:0] d, input logic [1:0] ch);
        in_byte = v; dma_req_byte = d; dma_chan = ch; stat_wr = 1'b1;
        tick();
        stat_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R4: reset state seen under handshake source
        check("R4 flag after reset", {7'd0, status_rdy}, 8'h00);
        check("R4 byte after reset", ret_byte, 8'h00);
        dma_tc_hit = 1'b1; legacy_req = 1'b1; #1;
        check("R4 flag ignores tc/req", {7'd0, status_rdy}, 8'h00);

        // R1 R2 R3: full sweep of fixed sources
        for (int m = 0; m < 3; m++) begin
            for (int t = 0; t < 2; t++) begin
                for (int q = 0; q < 2; q++) begin
                    mode_sel = m[1:0]; dma_tc_hit = t[0]; legacy_req = q[0];
                    #1;
                    if (m == 0) check("R1 off", {7'd0, status_rdy}, 8'h00);
                    else if (m == 1) check("R2 tc", {7'd0, status_rdy}, {7'd0, t[0]});
                    else check("R3 tc|req", {7'd0, status_rdy}, {7'd0, t[0] | q[0]});
                end
            end
        end
        dma_tc_hit = 1'b0; legacy_req = 1'b0;

        // R12: strobes outside handshake source are ignored
        for (int m = 0; m < 3; m++) begin
            mode_sel = m[1:0];
            strobe(8'hA5 ^ m[7:0], 8'hFF, 2'd1);
            mode_sel = 2'b11; #1;
            check("R12 flag unchanged", {7'd0, status_rdy}, 8'h00);
            check("R12 byte unchanged", ret_byte, 8'h00);
        end

        // R5 R6 R7 R8: splice sweep over every channel
        mode_sel = 2'b11;
        for (int ch = 0; ch < 4; ch++) begin
            for (int v = 0; v < 256; v += 17) begin
                logic [7:0] d;
                d = {v[3:0], v[7:4]} ^ 8'h5A;
                strobe(v[7:0], d, ch[1:0]);
                check("R5 flag set", {7'd0, status_rdy}, 8'h01);
                check(ch == 0 ? "R6 splice ch0" : "R7 splice other", ret_byte,
                      expect_byte(v[7:0], d, ch[1:0]));
                snoop_full(); tick(); snoop_idle();
                check("R8 full read clears", {7'd0, status_rdy}, 8'h00);
            end
        end

        // R8: every partial qualifier set keeps the flag
        for (int c = 1; c < 8; c++) begin
            for (int a = 0; a < 2; a++) begin
                strobe(8'h3C, 8'hC3, 2'd2);
                snoop_cs_n = c[0];
                snoop_addr = c[1] ? (a == 0 ? 8'h09 : 8'h88) : 8'h08;
                data_rdy_n = c[2];
                tick();
                check("R8 partial read keeps", {7'd0, status_rdy}, 8'h01);
                snoop_full(); tick(); snoop_idle();
                check("R8 full read clears", {7'd0, status_rdy}, 8'h00);
            end
        end

        // R9: set beats clear, from flag low and from flag high
        snoop_full();
        strobe(8'h11, 8'h22, 2'd0);
        check("R9 set wins from 0", {7'd0, status_rdy}, 8'h01);
        strobe(8'h44, 8'h88, 2'd3);
        check("R9 set wins from 1", {7'd0, status_rdy}, 8'h01);
        snoop_idle();

        // R10: byte holds through input changes and a clearing read
        strobe(8'hF0, 8'h0F, 2'd0);
        held = expect_byte(8'hF0, 8'h0F, 2'd0);
        for (int k = 0; k < 4; k++) begin
            in_byte = 8'h1F * k[7:0]; dma_req_byte = ~in_byte; dma_chan = k[1:0];
            if (k == 2) snoop_full();
            tick();
            snoop_idle();
            check("R10 byte holds", ret_byte, held);
        end
        check("R10 flag cleared meanwhile", {7'd0, status_rdy}, 8'h00);

        // R11: leaving handshake source keeps the flag
        strobe(8'h5A, 8'hA5, 2'd1);
        mode_sel = 2'b01; dma_tc_hit = 1'b0; #1;
        check("R11 other source shown", {7'd0, status_rdy}, 8'h00);
        snoop_full(); tick(); snoop_idle();
        mode_sel = 2'b00; tick();
        mode_sel = 2'b11; #1;
        check("R11 flag kept set", {7'd0, status_rdy}, 8'h01);
        snoop_full(); tick(); snoop_idle();
        check("R11 clears back in handshake", {7'd0, status_rdy}, 8'h00);
        mode_sel = 2'b10; tick(); tick();
        mode_sel = 2'b11; #1;
        check("R11 flag kept clear", {7'd0, status_rdy}, 8'h00);

        finish_run();
    end

endmodule